// File: doc/BRIEF.md
# Floating-Point Status Flag Update Unit

This block sits after a double-precision fused multiply-add datapath and turns that datapath's exception outcome into updates of a floating-point status and control register. For each operation it receives six exception flags, a round-up indication, the 64-bit rounded result and the enable bits for the exception classes. The six flags are signalling-NaN invalid, infinity-times-zero invalid, infinity-minus-infinity invalid, overflow, underflow and inexact. From these inputs it updates the sticky exception bits, the summary bits, the fraction-rounded and fraction-inexact bits and a 5-bit result class code. It also drives the write port of a 128-bit destination register.

The three invalid flags are ORed together. If that combined invalid condition is present while invalid trapping is enabled, the unit keeps the result class and clears the fraction bits. It still writes the result into the lower doubleword, but it leaves the upper doubleword alone. In every other case it writes the result into the lower doubleword, writes zeros into the upper doubleword and records the class of the result. If the unit-enable input is low, a valid operation changes nothing and raises an unavailable indication instead.

Top module: `fpstat_update`

## Requirements
- R1: On a clock edge where `vld` and `unit_en` are both high, each raised flag sets its own sticky bit. The bit positions in `stk` are: 5 signalling-NaN, 4 infinity-times-zero, 3 infinity-minus-infinity, 2 overflow, 1 underflow, 0 inexact. Sticky bits are never cleared by an operation.
- R2: `fx` becomes 1 after an operation that takes at least one sticky bit from 0 to 1. Once set, it stays at 1 until it is cleared.
- R3: `vx` equals the OR of `stk[5:3]`. `fex` equals the OR of four terms: (`|stk[5:3]` AND `inv_en`), (`stk[2]` AND `ovf_en`), (`stk[1]` AND `unf_en`) and (`stk[0]` AND `inx_en`).
- R4: An operation is trapping when `inv_en` is 1 and at least one of `f_snan`, `f_imz` or `f_isi` is 1.
- R5: After a non-trapping operation, `fi` equals `f_inx`, `fr` equals `rnd_up` and `fprf` holds the class of `res`. During that operation `dst_we` is 2'b11 and `dst_wdata[127:64]` is zero.
- R6: After a trapping operation, `fr` and `fi` are 0 and `fprf` is unchanged. During that operation `dst_we` is 2'b01.
- R7: During any operation, `dst_we[0]` is 1 and `dst_wdata[63:0]` equals `res`.
- R8: The class codes are: any NaN 10001, -infinity 01001, -normal 01000, -denormal 11000, -zero 10010, +zero 00010, +denormal 10100, +normal 00100, +infinity 00101. The class is decoded from the sign, the 11-bit exponent and the 52-bit fraction.
- R9: When `vld` is high and `unit_en` is low, `unavail` is 1 and `dst_we` is 0, and no status field changes on that edge.
- R10: `clr` clears `stk` and `fx` on the clock edge. An operation in the same cycle is applied after the clear. Reset sets every status output, including `fprf`, to 0.
- R11: While `vld` is low, `dst_we` is 0 and no status field changes, whatever the flag inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the sticky bits and `fx` |
| vld | input | 1 | Operation strobe |
| unit_en | input | 1 | Unit enable; when low, an operation is refused |
| f_snan | input | 1 | Signalling-NaN invalid flag |
| f_imz | input | 1 | Infinity-times-zero invalid flag |
| f_isi | input | 1 | Infinity-minus-infinity invalid flag |
| f_ovf | input | 1 | Overflow flag |
| f_unf | input | 1 | Underflow flag |
| f_inx | input | 1 | Inexact flag |
| rnd_up | input | 1 | Result magnitude was rounded up |
| res | input | DW | Rounded result |
| inv_en | input | 1 | Invalid trap enable |
| ovf_en | input | 1 | Overflow enable |
| unf_en | input | 1 | Underflow enable |
| inx_en | input | 1 | Inexact enable |
| stk | output | 6 | Sticky exception bits |
| fx | output | 1 | Exception summary |
| vx | output | 1 | Invalid summary |
| fex | output | 1 | Enabled-exception summary |
| fr | output | 1 | Fraction rounded |
| fi | output | 1 | Fraction inexact |
| fprf | output | 5 | Result class code |
| unavail | output | 1 | Operation refused because the unit is disabled |
| dst_we | output | 2 | Destination doubleword write enables |
| dst_wdata | output | 2*DW | Destination write data |

## Verification
The hardest case to reach from the ports is an operation that meets sticky bits that are already set, combined with a trap decision that depends on that operation's own flags. Every check of "no new 0-to-1 transition", and of a trapping update that keeps an older class, needs a specific prior register state. The bench therefore starts each step with an operation that clears and preloads in the same cycle, using every 6-bit sticky pattern. It then applies every 6-bit flag pattern with invalid trapping both off and on, and follows with either a refused operation or an idle cycle whose flags are all high.

// File: rtl/fpstat_update.sv
module fpstat_update #(
  parameter int DW = 64,
  parameter int EW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          vld,
  input  logic          unit_en,
  input  logic          f_snan,
  input  logic          f_imz,
  input  logic          f_isi,
  input  logic          f_ovf,
  input  logic          f_unf,
  input  logic          f_inx,
  input  logic          rnd_up,
  input  logic [DW-1:0] res,
  input  logic          inv_en,
  input  logic          ovf_en,
  input  logic          unf_en,
  input  logic          inx_en,
  output logic [5:0]    stk,
  output logic          fx,
  output logic          vx,
  output logic          fex,
  output logic          fr,
  output logic          fi,
  output logic [4:0]    fprf,
  output logic          unavail,
  output logic [1:0]    dst_we,
  output logic [2*DW-1:0] dst_wdata
);
  localparam int FW = DW - EW - 1;

  logic          op, inv_any, trap;
  logic [5:0]    flags, stk_base;
  logic          fx_base;
  logic          sgn, e_max, e_min, f_nz;
  logic [4:0]    cls;

  assign op       = vld & unit_en;
  assign flags    = {f_snan, f_imz, f_isi, f_ovf, f_unf, f_inx};
  assign inv_any  = |flags[5:3];
  assign trap     = inv_en & inv_any;
  assign stk_base = clr ? 6'b0 : stk;
  assign fx_base  = clr ? 1'b0 : fx;

  assign sgn   = res[DW-1];
  assign e_max = &res[DW-2:FW];
  assign e_min = ~|res[DW-2:FW];
  assign f_nz  = |res[FW-1:0];

  always_comb begin
    if (e_max && f_nz)      cls = 5'b10001;
    else if (e_max)         cls = sgn ? 5'b01001 : 5'b00101;
    else if (e_min && f_nz) cls = sgn ? 5'b11000 : 5'b10100;
    else if (e_min)         cls = sgn ? 5'b10010 : 5'b00010;
    else                    cls = sgn ? 5'b01000 : 5'b00100;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk  <= '0;
      fx   <= 1'b0;
      fr   <= 1'b0;
      fi   <= 1'b0;
      fprf <= '0;
    end else begin
      if (clr) begin
        stk <= '0;
        fx  <= 1'b0;
      end
      if (op) begin
        stk <= stk_base | flags;
        fx  <= fx_base | (|(flags & ~stk_base));
        if (trap) begin
          fr <= 1'b0;
          fi <= 1'b0;
        end else begin
          fr   <= rnd_up;
          fi   <= f_inx;
          fprf <= cls;
        end
      end
    end
  end

  assign vx  = |stk[5:3];
  assign fex = (vx & inv_en) | (stk[2] & ovf_en) | (stk[1] & unf_en) | (stk[0] & inx_en);

  assign unavail   = vld & ~unit_en;
  assign dst_we    = {op & ~trap, op};
  assign dst_wdata = {{DW{1'b0}}, res};

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stk & $past(stk)) == $past(stk)));

  // R6
  trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && unit_en && inv_en && (f_snan || f_imz || f_isi)) |=> (!fr && !fi && $stable(fprf)));

  // R9
  refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !unit_en && !clr) |=> ($stable(stk) && $stable(fx) && $stable(fprf) && $stable(fr) && $stable(fi)));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !clr) |=> ($stable(stk) && $stable(fx) && $stable(fprf) && $stable(fr) && $stable(fi)));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we[1] |-> (dst_we[0] && dst_wdata[2*DW-1:DW] == '0));

  // R2
  fx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fx && !clr) |=> fx);
endmodule

// File: tb/test_fpstat_update.sv
module test_fpstat_update;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0, unit_en = 1'b1;
  logic [5:0] fl = '0;
  logic rnd_up = 1'b0, inv_en = 1'b0, ovf_en = 1'b0, unf_en = 1'b0, inx_en = 1'b0;
  logic [63:0] res = '0;
  logic [5:0] stk;
  logic fx, vx, fex, fr, fi, unavail;
  logic [4:0] fprf;
  logic [1:0] dst_we;
  logic [127:0] dst_wdata;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [63:0] tv [10];
  logic [4:0]  tc [10];

  always #5 clk = ~clk;

  fpstat_update i_fpstat_update (
    .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .unit_en(unit_en),
    .f_snan(fl[5]), .f_imz(fl[4]), .f_isi(fl[3]), .f_ovf(fl[2]), .f_unf(fl[1]), .f_inx(fl[0]),
    .rnd_up(rnd_up), .res(res), .inv_en(inv_en), .ovf_en(ovf_en), .unf_en(unf_en), .inx_en(inx_en),
    .stk(stk), .fx(fx), .vx(vx), .fex(fex), .fr(fr), .fi(fi), .fprf(fprf),
    .unavail(unavail), .dst_we(dst_we), .dst_wdata(dst_wdata));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tv[0] = 64'h7FF8000000000000; tc[0] = 5'b10001;
    tv[1] = 64'hFFF0000000000000; tc[1] = 5'b01001;
    tv[2] = 64'hC000000000000000; tc[2] = 5'b01000;
    tv[3] = 64'h8000000000000001; tc[3] = 5'b11000;
    tv[4] = 64'h8000000000000000; tc[4] = 5'b10010;
    tv[5] = 64'h0000000000000000; tc[5] = 5'b00010;
    tv[6] = 64'h000FFFFFFFFFFFFF; tc[6] = 5'b10100;
    tv[7] = 64'h3FF0000000000000; tc[7] = 5'b00100;
    tv[8] = 64'h7FF0000000000000; tc[8] = 5'b00101;
    tv[9] = 64'hFFF0000000000001; tc[9] = 5'b10001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset", {stk, fx, fr, fi, fprf}, '0);

    for (int p = 0; p < 64; p++) begin
      for (int f = 0; f < 64; f++) begin
        for (int e = 0; e < 2; e++) begin
          logic trap, fxa, fxb, vxe, fexe;
          logic [5:0] se;
          logic [4:0] ca, cb;
          logic [2:0] en3;
          // cycle A: clear plus preload in the same cycle
          clr = 1'b1; vld = 1'b1; unit_en = 1'b1; fl = p[5:0]; inv_en = 1'b0;
          ovf_en = 1'b0; unf_en = 1'b0; inx_en = 1'b0; rnd_up = 1'b0;
          res = tv[p % 10]; ca = tc[p % 10];
          @(negedge clk);
          fxa = (p != 0);
          // R10 clear then apply
          chk("R10 clear+op stk", stk, p[5:0]);
          chk("R2 fx preload", fx, fxa);
          // R8 class
          chk("R8 class A", fprf, ca);
          // cycle B
          clr = 1'b0; fl = f[5:0]; inv_en = e[0];
          en3 = p[2:0] ^ f[5:3];
          {ovf_en, unf_en, inx_en} = en3;
          rnd_up = f[1] ^ p[0];
          res = tv[(p + f) % 10]; cb = tc[(p + f) % 10];
          trap = e[0] & (|f[5:3]);
          #1;
          // R4 R5 R6 R7 write port
          chk("R4 R5 R6 dst_we", dst_we, trap ? 2'b01 : 2'b11);
          chk("R7 dst low", dst_wdata[63:0], res);
          if (!trap) chk("R5 dst high zero", dst_wdata[127:64], 64'h0);
          @(negedge clk);
          se = p[5:0] | f[5:0];
          fxb = fxa | ((f[5:0] & ~p[5:0]) != 0);
          vxe = |se[5:3];
          fexe = (vxe & e[0]) | (se[2] & en3[2]) | (se[1] & en3[1]) | (se[0] & en3[0]);
          // R1 sticky
          chk("R1 sticky", stk, se);
          chk("R2 fx", fx, fxb);
          chk("R3 vx fex", {vx, fex}, {vxe, fexe});
          if (trap) chk("R6 trap fields", {fr, fi, fprf}, {2'b00, ca});
          else      chk("R5 fields", {fr, fi, fprf}, {rnd_up, f[0], cb});
          // cycle C: refused op or idle, all flags high
          fl = 6'h3F; inv_en = 1'b1; rnd_up = ~rnd_up; res = tv[(f + 3) % 10];
          if (f % 2 == 1) begin vld = 1'b1; unit_en = 1'b0; end
          else begin vld = 1'b0; unit_en = 1'b1; end
          #1;
          if (f % 2 == 1) chk("R9 refused port", {unavail, dst_we}, 3'b100);
          else            chk("R11 idle port", {unavail, dst_we}, 3'b000);
          @(negedge clk);
          chk((f % 2 == 1) ? "R9 no change" : "R11 no change",
              {stk, fx, fr, fi, fprf},
              {se, fxb, (trap ? 1'b0 : ~rnd_up), (trap ? 1'b0 : f[0]), (trap ? ca : cb)});
        end
      end
    end

    // R10 standalone clear
    vld = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 clear", {stk, fx}, 7'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule